// File: doc/BRIEF.md
# Page-Erase Nonvolatile Byte Store Controller

This block models a small nonvolatile byte store behind a simple request interface. Each request carries an operation code, a 16-bit address and a data byte. The store behaves like flash. A byte starts erased at 0xFF. A byte can be programmed only while it still holds 0xFF. To return bytes to the erased state, a whole page must be erased. A page erase is possible only while an enable bit in a configuration register is set.

Programming and erasing each keep the block busy for a parameterised number of cycles. During that time every new request is turned away. A write that targets a byte which is already programmed does not change the byte. Instead it raises a sticky error flag. Software reads that flag at a status address, and the read also clears it. The configuration register resets to zero, so erasing is disabled after reset. The storage is built from flip-flops, which lets a whole page clear in a single cycle.

Top module: `nvs_store_ctrl`

## Requirements
- R1: After reset, busy and prog_err are 0, req_ready is 1, the configuration register reads 0x00, and every store byte reads 0xFF.
- R2: The store covers addresses 0xF800 to 0xFBFF, with byte offset = address − 0xF800. A read is accepted in the cycle where req_valid and req_ready are both high, with req_op 2'b00. In the next cycle, rd_valid is 1 and rd_data holds the addressed byte.
- R3: A write (req_op 2'b01) to a store byte that holds 0xFF stores req_wdata. busy then goes high for exactly PROG_CYC cycles, starting in the next cycle.
- R4: A write to a store byte that does not hold 0xFF leaves the byte unchanged, sets prog_err in the next cycle, and does not raise busy.
- R5: prog_err stays set until a read of the status address 0x0091 is accepted. That read returns 0x01 when the flag is set and 0x00 otherwise, and it clears the flag.
- R6: An erase (req_op 2'b10) to a store address, accepted while bit 2 of the configuration register is 1, sets all 32 bytes of page address[9:5] to 0xFF. It leaves every other page unchanged and holds busy high for exactly ERASE_CYC cycles.
- R7: An erase accepted while configuration bit 2 is 0 is ignored: no byte changes and busy stays 0.
- R8: While busy is 1, req_ready is 0, and any request presented has no effect on the store, the registers or rd_valid.
- R9: A write to address 0x0090 loads the whole configuration byte, and a read of 0x0090 returns it.
- R10: Writes and erases to addresses outside the store, the configuration address and the status address are ignored, and reads there return 0x00. Op code 2'b11 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 read, 01 write, 10 page erase, 11 no operation |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request can be accepted this cycle |
| rd_valid | output | 1 | Read data valid (one cycle after acceptance) |
| rd_data | output | 8 | Read data |
| busy | output | 1 | Program or erase in progress |
| prog_err | output | 1 | Sticky write-to-programmed-byte error |

## Verification
The hardest situations to reach from the ports are a write colliding with a byte that is already programmed, and an erase arriving while the enable bit is in one particular state. Uniform addresses across 1024 bytes would almost never revisit a byte.

The random stimulus therefore concentrates its addresses on three low pages and the last page. It mixes in configuration writes whose enable bit is random, so both erase outcomes keep recurring. Directed sequences also present a request in the middle of a busy window, then read the target byte back to show that nothing changed.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   typedef enum logic [1:0] {
      NVS_RD  = 2'b00,
      NVS_WR  = 2'b01,
      NVS_ER  = 2'b10,
      NVS_NOP = 2'b11
   } nvs_op_e;

   typedef struct packed {
      logic in_store;
      logic in_cfg;
      logic in_stat;
   } nvs_hit_t;

   localparam logic [7:0] NVS_BLANK = 8'hFF;
endpackage

// File: rtl/nvs_decode.sv
module nvs_decode
   import nvs_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int OFF_W     = 10,
   parameter int BASE_ADDR = 'hF800,
   parameter int DEPTH     = 1024,
   parameter int CFG_ADDR  = 'h90,
   parameter int STAT_ADDR = 'h91
) (
   input  logic [ADDR_W-1:0] addr,
   output nvs_hit_t          hit,
   output logic [OFF_W-1:0]  offset
);
   localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE_ADDR + DEPTH - 1);

   always_comb begin
      hit.in_store = (addr >= LO_A) && (addr <= HI_A);
      hit.in_cfg   = (addr == ADDR_W'(CFG_ADDR));
      hit.in_stat  = (addr == ADDR_W'(STAT_ADDR));
      offset       = addr[OFF_W-1:0];
   end
endmodule

// File: rtl/nvs_busy_timer.sv
module nvs_busy_timer #(
   parameter int PROG_CYC  = 4,
   parameter int ERASE_CYC = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_wr,
   input  logic start_er,
   output logic busy
);
   localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_er) begin
         cnt_q <= CNT_W'(ERASE_CYC);
      end else if (start_wr) begin
         cnt_q <= CNT_W'(PROG_CYC);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/nvs_array.sv
module nvs_array
   import nvs_pkg::*;
#(
   parameter int NUM_PAGES  = 32,
   parameter int PAGE_BYTES = 32,
   parameter int DATA_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [$clog2(NUM_PAGES*PAGE_BYTES)-1:0] off,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 er_en,
   output logic [DATA_W-1:0]    rdata
);
   localparam int DEPTH = NUM_PAGES * PAGE_BYTES;
   localparam int OFF_W = $clog2(DEPTH);
   localparam int BYT_W = $clog2(PAGE_BYTES);
   localparam int PG_W  = OFF_W - BYT_W;
   localparam logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}};

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PG_W-1:0]   page_sel;

   assign page_sel = off[OFF_W-1:BYT_W];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mem[i] <= BLANK;
         end else if (er_en && page_sel == PG_W'(i / PAGE_BYTES)) begin
            mem[i] <= BLANK;
         end else if (wr_en && off == OFF_W'(i)) begin
            mem[i] <= wdata;
         end
      end
   end

   assign rdata = mem[off];
endmodule

// File: rtl/nvs_store_ctrl.sv
module nvs_store_ctrl
   import nvs_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int BASE_ADDR    = 'hF800,
   parameter int NUM_PAGES    = 32,
   parameter int PAGE_BYTES   = 32,
   parameter int CFG_ADDR     = 'h90,
   parameter int STAT_ADDR    = 'h91,
   parameter int ERASE_EN_BIT = 2,
   parameter int PROG_CYC     = 4,
   parameter int ERASE_CYC    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_wdata,
   output logic              req_ready,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              busy,
   output logic              prog_err
);
   localparam int DEPTH = NUM_PAGES * PAGE_BYTES;
   localparam int OFF_W = $clog2(DEPTH);

   if ((1 << $clog2(PAGE_BYTES)) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if ((1 << OFF_W) != DEPTH || (BASE_ADDR % DEPTH) != 0) begin : g_bad_base
      $error("store size must be a power of two and BASE_ADDR aligned to it");
   end
   if (PROG_CYC < 1 || ERASE_CYC < 1) begin : g_bad_cyc
      $error("busy delays must be at least one cycle");
   end
   if (ERASE_EN_BIT < 0 || ERASE_EN_BIT > 7) begin : g_bad_bit
      $error("ERASE_EN_BIT must index the configuration byte");
   end

   nvs_hit_t         hit;
   logic [OFF_W-1:0] off;
   logic [7:0]       cur;
   logic [7:0]       cfg_q;
   logic             acc, is_prog;
   logic             do_wr, wr_bad, do_er, cfg_wr, stat_rd;
   logic             stat_sel, erase_en;
   nvs_op_e          op;

   nvs_decode #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BASE_ADDR(BASE_ADDR), .DEPTH(DEPTH),
      .CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR)
   ) u_dec (
      .addr(req_addr), .hit(hit), .offset(off)
   );

   assign op       = nvs_op_e'(req_op);
   assign acc      = req_valid && req_ready;
   assign is_prog  = (cur != NVS_BLANK);
   assign erase_en = cfg_q[ERASE_EN_BIT];
   assign stat_sel = hit.in_stat;

   assign do_wr   = acc && op == NVS_WR && hit.in_store && !is_prog;
   assign wr_bad  = acc && op == NVS_WR && hit.in_store && is_prog;
   assign do_er   = acc && op == NVS_ER && hit.in_store && erase_en;
   assign cfg_wr  = acc && op == NVS_WR && hit.in_cfg;
   assign stat_rd = acc && op == NVS_RD && hit.in_stat;

   nvs_array #(
      .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES), .DATA_W(8)
   ) u_arr (
      .clk(clk), .rst_n(rst_n), .wr_en(do_wr), .off(off),
      .wdata(req_wdata), .er_en(do_er), .rdata(cur)
   );

   nvs_busy_timer #(
      .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
   ) u_tmr (
      .clk(clk), .rst_n(rst_n), .start_wr(do_wr), .start_er(do_er), .busy(busy)
   );

   assign req_ready = !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q    <= 8'h00;
         prog_err <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= 8'h00;
      end else begin
         if (cfg_wr) cfg_q <= req_wdata;
         if (wr_bad)       prog_err <= 1'b1;
         else if (stat_rd) prog_err <= 1'b0;
         rd_valid <= acc && op == NVS_RD;
         if (acc && op == NVS_RD) begin
            if (hit.in_store)     rd_data <= cur;
            else if (hit.in_cfg)  rd_data <= cfg_q;
            else if (hit.in_stat) rd_data <= {7'b0, prog_err};
            else                  rd_data <= 8'h00;
         end
      end
   end
endmodule

// File: rtl/nvs_chk.sv
module nvs_chk
   import nvs_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [1:0] req_op,
   input logic       req_ready,
   input logic       rd_valid,
   input logic       busy,
   input logic       prog_err,
   input logic       stat_sel,
   input logic       erase_en
);
   // R2
   rd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(req_valid && req_ready && req_op == NVS_RD));

   // R4
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_err) |-> $past(req_valid && req_ready && req_op == NVS_WR));

   // R5
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_err) |-> $past(req_valid && req_ready && req_op == NVS_RD && stat_sel));

   // R7
   erase_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_op == NVS_ER && !erase_en && !busy) |=> !busy);

   // R8
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid && req_ready));

   // R8
   busy_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !rd_valid);
endmodule

bind nvs_store_ctrl nvs_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
   .req_ready(req_ready), .rd_valid(rd_valid), .busy(busy),
   .prog_err(prog_err), .stat_sel(stat_sel), .erase_en(erase_en)
);

// File: tb/sim_nvs_store_ctrl.sv
`timescale 1ns/1ps
module sim_nvs_store_ctrl;
   localparam int PROG  = 4;
   localparam int ERASE = 12;
   localparam logic [15:0] BASE = 16'hF800;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_op = 2'b11;
   logic [15:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic req_ready, rd_valid, busy, prog_err;
   logic [7:0] rd_data;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   logic [7:0] mdl [1024];
   logic [7:0] m_cfg;
   logic       m_err;

   always #2 clk = ~clk;

   nvs_store_ctrl #(.PROG_CYC(PROG), .ERASE_CYC(ERASE)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .prog_err(prog_err)
   );

   function automatic bit in_store(logic [15:0] a);
      return a >= BASE && a <= 16'hFBFF;
   endfunction

   function automatic logic [7:0] exp_read(logic [15:0] a);
      if (in_store(a)) return mdl[a[9:0]];
      if (a == 16'h0090) return m_cfg;
      if (a == 16'h0091) return {7'b0, m_err};
      return 8'h00;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // issue one request from a negedge; returns at the negedge after acceptance
   task automatic issue(logic [1:0] op, logic [15:0] a, logic [7:0] d);
      req_op = op; req_addr = a; req_wdata = d; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; req_op = 2'b11;
   endtask

   task automatic busy_len(output int n);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
   endtask

   task automatic do_read(logic [15:0] a, string tag);
      logic [7:0] e;
      e = exp_read(a);
      issue(2'b00, a, 8'h00);
      chk({tag, " rd_valid"}, rd_valid, 1);
      chk({tag, " rd_data"}, rd_data, e);
      if (a == 16'h0091) m_err = 1'b0;
   endtask

   task automatic do_write(logic [15:0] a, logic [7:0] d, string tag);
      int eb, n;
      eb = 0;
      if (in_store(a)) begin
         if (mdl[a[9:0]] == 8'hFF) begin mdl[a[9:0]] = d; eb = PROG; end
         else m_err = 1'b1;
      end else if (a == 16'h0090) m_cfg = d;
      issue(2'b01, a, d);
      chk({tag, " prog_err"}, prog_err, m_err);
      busy_len(n);
      chk({tag, " busy cycles"}, n, eb);
   endtask

   task automatic do_erase(logic [15:0] a, string tag);
      int eb, n;
      eb = 0;
      if (in_store(a) && m_cfg[2]) begin
         for (int i = 0; i < 32; i++) mdl[{a[9:5], 5'(i)}] = 8'hFF;
         eb = ERASE;
      end
      issue(2'b10, a, 8'h00);
      busy_len(n);
      chk({tag, " busy cycles"}, n, eb);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      void'($urandom(32'd4242));
      for (int i = 0; i < 1024; i++) mdl[i] = 8'hFF;
      m_cfg = 8'h00; m_err = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 prog_err", prog_err, 0);
      chk("R1 req_ready", req_ready, 1);
      do_read(16'h0090, "R1 cfg");
      do_read(16'hF800, "R1 first byte");
      do_read(16'hFBFF, "R1 last byte");

      // R3 / R2 program and read back
      do_write(16'hF805, 8'h3C, "R3 program");
      do_read(16'hF805, "R2 readback");
      do_write(16'hF820, 8'hA5, "R3 page1");
      // R4 rewrite of programmed byte
      do_write(16'hF805, 8'h11, "R4 rewrite");
      do_read(16'hF805, "R4 unchanged");
      do_write(16'hF805, 8'h00, "R4 again");
      // R5 sticky then cleared by status read
      chk("R5 sticky", prog_err, 1);
      do_read(16'h0091, "R5 status set");
      chk("R5 cleared", prog_err, 0);
      do_read(16'h0091, "R5 status clear");

      // R7 erase while disabled
      do_erase(16'hF800, "R7 disabled");
      do_read(16'hF805, "R7 byte kept");
      // R9 configuration register
      do_write(16'h0090, 8'h04, "R9 cfg write");
      do_read(16'h0090, "R9 cfg read");
      // R6 page erase
      do_erase(16'hF81F, "R6 erase page0");
      do_read(16'hF805, "R6 erased byte");
      do_read(16'hF820, "R6 other page kept");
      do_write(16'hF805, 8'h77, "R6 reprogram");
      do_write(16'h0090, 8'hFB, "R9 cfg bit2 low");
      do_erase(16'hF805, "R7 disabled again");
      do_read(16'hF805, "R7 kept again");

      // R10 outside addresses and NOP
      do_write(16'hF7FF, 8'h12, "R10 below");
      do_read(16'hF7FF, "R10 below read");
      do_write(16'hFC00, 8'h34, "R10 above");
      do_read(16'hFC00, "R10 above read");
      do_write(16'hFBFF, 8'h5E, "R2 last byte");
      do_read(16'hFBFF, "R2 last byte read");
      issue(2'b11, 16'hF900, 8'h00);
      chk("R10 nop no read", rd_valid, 0);
      chk("R10 nop no busy", busy, 0);

      // R8 requests during busy have no effect
      req_op = 2'b01; req_addr = 16'hF830; req_wdata = 8'h5A; req_valid = 1'b1;
      mdl[10'h030] = 8'h5A;
      @(negedge clk);
      req_addr = 16'hF900; req_wdata = 8'h77;
      chk("R8 ready low", req_ready, 0);
      chk("R8 busy", busy, 1);
      @(negedge clk);
      req_op = 2'b00;
      @(negedge clk);
      chk("R8 no read", rd_valid, 0);
      req_valid = 1'b0; req_op = 2'b11;
      busy_len(n);
      do_read(16'hF900, "R8 untouched");
      do_read(16'hF830, "R8 first write");

      // random mix
      for (int k = 0; k < 500; k++) begin
         int r, o;
         logic [15:0] a;
         r = $urandom % 16;
         if (r < 12) begin
            int pg;
            pg = (r < 9) ? (r % 3) : 31;
            a = BASE + 16'(pg * 32) + 16'($urandom % 8);
         end else if (r == 12) a = 16'h0090;
         else if (r == 13) a = 16'h0091;
         else if (r == 14) a = 16'h0100;
         else a = ($urandom % 2) ? 16'hF7FF : 16'hFC00;
         o = $urandom % 10;
         if (o < 4) do_read(a, "R2 rnd read");
         else if (o < 8) do_write(a, 8'($urandom), "R3 rnd write");
         else do_erase(a, "R6 rnd erase");
      end
      for (int p = 0; p < 3; p++)
         for (int b = 0; b < 8; b++) do_read(BASE + 16'(p * 32 + b), "R6 rnd final");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule